// File: doc/BRIEF.md
# Delayed-Write Store Stage for a Direct-Mapped Data Cache

This block sits in the memory stage in front of a direct-mapped data cache. It lets a store that hits finish in one cycle. Every request reads the tag array and the data array in the same cycle, both indexed by the request address. When a store hits, its word address, data and byte enables go into a single holding entry and do not go to the data array yet. The held store is written into the data array at the clock edge that ends the tag-check cycle of the next store hit. It can also be written by an explicit drain request.

While a store is held, a load to the same word address gets the held bytes merged over the array word. Loads to any other address see the array contents. A store that misses changes nothing. A small install port loads a tag and a whole data word into a line, which stands in for the refill path. That port may only be used while the holding entry is empty and no request is active.

Top module: `stbuf_cache`

## Requirements
- R1: After reset every line's tag is invalid, so every load or store misses (`rsp_hit_o` low) until a line is installed.
- R2: An install (`fill_en_i`) writes the tag and the whole data word of the line selected by `fill_addr_i`. A later load to that address hits in its own cycle and returns the installed word. An install is allowed only while no request is active and no store is held.
- R3: A load whose tag differs from the stored tag at its index misses.
- R4: A store that hits is held. A load in a later cycle to the same word address returns the held data, even though the array has not been written yet.
- R5: Bit i of `req_be_i` selects byte i, which is bits 8i+7 down to 8i. On a forwarded load, enabled bytes come from the held store and the other bytes come from the array word.
- R6: When a store hits while an entry is held, the held entry is written into the array at the edge that ends that cycle, and the new store replaces it. This also holds when both stores target the same word.
- R7: A store that misses neither writes the array nor changes the held entry.
- R8: `flush_i` with no store hit in the same cycle writes a held entry into the array and empties the holding entry. With an empty entry it has no effect.
- R9: A load to an address other than the held one returns the array word without merging.
- R10: For a store, `rsp_hit_o` reports the tag-check result in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W (12) | Word address: upper bits are the tag, lower INDEX_W bits the line index |
| req_wdata_i | input | DATA_W (32) | Store data |
| req_be_i | input | DATA_W/8 (4) | Store byte enables |
| flush_i | input | 1 | Drain the holding entry into the array |
| rsp_hit_o | output | 1 | Tag hit for the current request |
| rsp_rdata_o | output | DATA_W (32) | Load data, forwarded bytes merged in |
| fill_en_i | input | 1 | Install a line |
| fill_addr_i | input | ADDR_W (12) | Word address of the installed line |
| fill_data_i | input | DATA_W (32) | Data word of the installed line |

## Verification
A wrong held address or a wrong valid bit shows up at the ports on the first load to the held word: the returned bytes are stale. A lost commit stays hidden until another store replaces the entry or a flush empties it. It then shows on the next load of that word as old array data. A wrong byte-enable mask shows immediately as wrong bytes in a forwarded load. A tag error shows as a wrong hit flag in the request cycle itself.

// File: rtl/stbuf_pkg.sv
// Shared sizes for the delayed-write store stage.
// Assumes word addressing: the address carries no byte offset.
package stbuf_pkg;
    localparam int ADDR_W  = 12;
    localparam int INDEX_W = 4;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int TAG_W   = ADDR_W - INDEX_W;
endpackage

// File: rtl/stbuf_tags.sv
// Tag store with one valid bit per line.
// Reads are combinational. Writes happen only through the install port.
// Reset clears every valid bit; the tag bits themselves are not reset.
module stbuf_tags #(
    parameter int INDEX_W = 4,
    parameter int TAG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic [TAG_W-1:0]   rd_tag,
    output logic               rd_vld,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]   wr_tag
);
    localparam int LINES = 1 << INDEX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] vld_q;

    // Valid bits: cleared by reset, set when a line is installed.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= 1'b1;
    end

    // Tag storage: written on install.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    // Combinational lookup.
    always_comb begin
        rd_tag = tag_q[rd_idx];
        rd_vld = vld_q[rd_idx];
    end
endmodule

// File: rtl/stbuf_data.sv
// Data store with per-byte write enables.
// A full-word install and a held-store commit share the one write port.
// Assumes the two never occur in the same cycle; the top checks this.
module stbuf_data #(
    parameter int INDEX_W = 4,
    parameter int DATA_W  = 32
) (
    input  logic                  clk,
    input  logic [INDEX_W-1:0]    rd_idx,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  fill_en,
    input  logic [INDEX_W-1:0]    fill_idx,
    input  logic [DATA_W-1:0]     fill_data,
    input  logic                  cmt_en,
    input  logic [INDEX_W-1:0]    cmt_idx,
    input  logic [DATA_W-1:0]     cmt_data,
    input  logic [DATA_W/8-1:0]   cmt_be
);
    localparam int LINES = 1 << INDEX_W;
    localparam int BE_W  = DATA_W / 8;

    logic [DATA_W-1:0]  mem_q [LINES];
    logic               wr_en;
    logic [INDEX_W-1:0] wr_idx;
    logic [DATA_W-1:0]  wr_data;
    logic [BE_W-1:0]    wr_be;

    // Write-port select: an install takes priority over a commit.
    always_comb begin
        wr_en   = fill_en | cmt_en;
        wr_idx  = fill_en ? fill_idx  : cmt_idx;
        wr_data = fill_en ? fill_data : cmt_data;
        wr_be   = fill_en ? '1        : cmt_be;
    end

    // One write lane per byte.
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) mem_q[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
        end
    end

    // Combinational read.
    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/stbuf_hold.sv
// Single-entry holding register for a store that hit.
// It asks for a commit whenever it is valid and is either replaced or drained.
// A store hit has priority over a drain request.
module stbuf_hold #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_hit,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [DATA_W-1:0]   st_data,
    input  logic [DATA_W/8-1:0] st_be,
    input  logic                drain,
    output logic                h_vld,
    output logic [ADDR_W-1:0]   h_addr,
    output logic [DATA_W-1:0]   h_data,
    output logic [DATA_W/8-1:0] h_be,
    output logic                cmt_en
);
    // Valid bit: set by a store hit, cleared by a drain with no store hit.
    always_ff @(posedge clk) begin
        if (!rst_n)      h_vld <= 1'b0;
        else if (st_hit) h_vld <= 1'b1;
        else if (drain)  h_vld <= 1'b0;
    end

    // Payload: captured on each store hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_addr <= '0;
            h_data <= '0;
            h_be   <= '0;
        end else if (st_hit) begin
            h_addr <= st_addr;
            h_data <= st_data;
            h_be   <= st_be;
        end
    end

    // Commit request: the held entry leaves for the array.
    assign cmt_en = h_vld && (st_hit || drain);

    p_park_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_hit |=> (h_vld && h_addr == $past(st_addr) && h_be == $past(st_be)));

    p_miss_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_hit && !drain) |=> ($stable(h_vld) && $stable(h_addr) && $stable(h_data)));

    p_drain_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !st_hit) |=> !h_vld);
endmodule

// File: rtl/stbuf_cache.sv
// Memory-stage front end of a direct-mapped data cache with delayed store writes.
// The tag and data arrays are read in parallel, indexed by the request address.
// A store that hits is held, and it is written into the array during the next
// store hit or on a drain request. A load to the held address gets the held
// bytes merged over the array word.
// Assumes an install happens only while no request is active and no store is held.
module stbuf_cache
    import stbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [BE_W-1:0]   req_be_i,
    input  logic              flush_i,
    output logic              rsp_hit_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    input  logic              fill_en_i,
    input  logic [ADDR_W-1:0] fill_addr_i,
    input  logic [DATA_W-1:0] fill_data_i
);
    logic [INDEX_W-1:0] req_idx;
    logic [TAG_W-1:0]   req_tag;
    logic [TAG_W-1:0]   arr_tag;
    logic               arr_vld;
    logic [DATA_W-1:0]  arr_word;
    logic               tag_hit;
    logic               st_hit;
    logic               h_vld;
    logic [ADDR_W-1:0]  h_addr;
    logic [DATA_W-1:0]  h_data;
    logic [BE_W-1:0]    h_be;
    logic               cmt_en;
    logic               fwd;

    // Split the request address into index and tag.
    always_comb begin
        req_idx = req_addr_i[INDEX_W-1:0];
        req_tag = req_addr_i[ADDR_W-1:INDEX_W];
    end

    stbuf_tags #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_idx),
        .rd_tag (arr_tag),
        .rd_vld (arr_vld),
        .wr_en  (fill_en_i),
        .wr_idx (fill_addr_i[INDEX_W-1:0]),
        .wr_tag (fill_addr_i[ADDR_W-1:INDEX_W])
    );

    stbuf_data #(.INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rd_idx    (req_idx),
        .rd_data   (arr_word),
        .fill_en   (fill_en_i),
        .fill_idx  (fill_addr_i[INDEX_W-1:0]),
        .fill_data (fill_data_i),
        .cmt_en    (cmt_en),
        .cmt_idx   (h_addr[INDEX_W-1:0]),
        .cmt_data  (h_data),
        .cmt_be    (h_be)
    );

    stbuf_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_hit  (st_hit),
        .st_addr (req_addr_i),
        .st_data (req_wdata_i),
        .st_be   (req_be_i),
        .drain   (flush_i),
        .h_vld   (h_vld),
        .h_addr  (h_addr),
        .h_data  (h_data),
        .h_be    (h_be),
        .cmt_en  (cmt_en)
    );

    // Tag check and forwarding decision for the current request.
    always_comb begin
        tag_hit = req_valid_i && arr_vld && (arr_tag == req_tag);
        st_hit  = tag_hit && req_we_i;
        fwd     = h_vld && (h_addr == req_addr_i);
    end

    // Byte merge: forwarded bytes replace array bytes.
    for (genvar b = 0; b < BE_W; b++) begin : g_merge
        assign rsp_rdata_o[8*b +: 8] = (fwd && h_be[b]) ? h_data[8*b +: 8]
                                                        : arr_word[8*b +: 8];
    end

    assign rsp_hit_o = tag_hit;

    p_replace_commits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_hit && h_vld) |-> cmt_en);

    p_fill_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en_i |-> (!req_valid_i && !h_vld));

    p_reset_misses_r1: assert property (@(posedge clk)
        !rst_n |=> !rsp_hit_o);
endmodule

// File: tb/test_stbuf_cache.sv
module test_stbuf_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_we_i = 1'b0;
    logic [11:0] req_addr_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic [3:0]  req_be_i = '0;
    logic        flush_i = 1'b0;
    logic        rsp_hit_o;
    logic [31:0] rsp_rdata_o;
    logic        fill_en_i = 1'b0;
    logic [11:0] fill_addr_i = '0;
    logic [31:0] fill_data_i = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    stbuf_cache i_stbuf_cache (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request cycle: drive at the falling edge, sample halfway to the rising edge.
    task automatic access(input string req, input logic we, input logic [11:0] a,
                          input logic [31:0] d, input logic [3:0] be,
                          input logic exp_hit, input bit chk_data, input logic [31:0] exp_d);
        @(negedge clk);
        req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = d; req_be_i = be;
        #5;
        check({req, " hit"}, {31'b0, rsp_hit_o}, {31'b0, exp_hit});
        if (chk_data) check({req, " data"}, rsp_rdata_o, exp_d);
        @(negedge clk);
        req_valid_i = 1'b0; req_we_i = 1'b0;
    endtask

    task automatic install(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        fill_en_i = 1'b1; fill_addr_i = a; fill_data_i = d;
        @(negedge clk);
        fill_en_i = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    task automatic t_reset();
        access("R1 load after reset", 1'b0, 12'h013, '0, '0, 1'b0, 1'b0, '0);
        access("R1 store after reset", 1'b1, 12'h024, 32'h1, 4'hF, 1'b0, 1'b0, '0);
    endtask

    task automatic t_install();
        install(12'h013, 32'h11223344);
        install(12'h024, 32'hAABBCCDD);
        access("R2 load installed", 1'b0, 12'h013, '0, '0, 1'b1, 1'b1, 32'h11223344);
        access("R3 other tag same index", 1'b0, 12'h023, '0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_forward();
        access("R10 store hit flag", 1'b1, 12'h013, 32'hEEFF0099, 4'b0101, 1'b1, 1'b0, '0);
        access("R4 R5 forwarded merge", 1'b0, 12'h013, '0, '0, 1'b1, 1'b1, 32'h11FF3399);
        access("R9 no merge elsewhere", 1'b0, 12'h024, '0, '0, 1'b1, 1'b1, 32'hAABBCCDD);
    endtask

    task automatic t_store_miss();
        access("R7 store miss flag", 1'b1, 12'h033, 32'hDEADBEEF, 4'hF, 1'b0, 1'b0, '0);
        access("R7 held entry kept", 1'b0, 12'h013, '0, '0, 1'b1, 1'b1, 32'h11FF3399);
    endtask

    task automatic t_replace();
        access("R6 second store", 1'b1, 12'h024, 32'h12000000, 4'b1000, 1'b1, 1'b0, '0);
        access("R6 first store committed", 1'b0, 12'h013, '0, '0, 1'b1, 1'b1, 32'h11FF3399);
        access("R6 new entry forwarded", 1'b0, 12'h024, '0, '0, 1'b1, 1'b1, 32'h12BBCCDD);
        access("R6 same-word store", 1'b1, 12'h024, 32'h00000077, 4'b0001, 1'b1, 1'b0, '0);
        access("R6 same-word merge", 1'b0, 12'h024, '0, '0, 1'b1, 1'b1, 32'h12BBCC77);
    endtask

    task automatic t_flush();
        drain();
        access("R8 drained word", 1'b0, 12'h024, '0, '0, 1'b1, 1'b1, 32'h12BBCC77);
        drain();
        access("R8 empty drain no effect", 1'b0, 12'h024, '0, '0, 1'b1, 1'b1, 32'h12BBCC77);
        install(12'h105, 32'h55667788);
        access("R2 install after drain", 1'b0, 12'h105, '0, '0, 1'b1, 1'b1, 32'h55667788);
        access("R3 miss on old tag", 1'b0, 12'h005, '0, '0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_install();
        t_forward();
        t_store_miss();
        t_replace();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule